// File: doc/BRIEF.md
# RMII Receive Byte Aligner

This block sits between an external Ethernet PHY and a MAC receive engine. It samples a 2-bit receive data bus and a combined carrier/data-valid line from the PHY. It hunts the preamble for the start-of-frame delimiter and then turns the dibits that follow into bytes that always start on the true byte boundary. A payload shifted by 2, 4 or 6 bits cannot occur, because the byte boundary comes only from the position of the delimiter and never from where carrier activity began.

The reference clock is shared with the PHY, so all inputs are sampled synchronously with no clock crossing. At 100 Mb/s a dibit is sampled on every clock. At 10 Mb/s each dibit is held for ten clocks and a mode input makes the block sample once in ten. Downstream logic sees a byte strobe with data, a first-byte flag, a last-byte flag and an alignment-error pulse for frames that end partway through a byte.

Top module: `rmii_rx_aligner`

## Requirements
- R1: While reset is high and on the first clock after it, `byte_valid`, `byte_sof`, `byte_eof` and `align_err` are all low.
- R2: With `mode_10m` low, the inputs are sampled on every clock. With `mode_10m` high, they are sampled once every ten clocks. A free-running count, cleared by reset, takes the sample on the 10th clock after reset release and on every 10th clock after that.
- R3: No byte is emitted from dibits seen before the delimiter. A carrier burst that contains no delimiter produces no output.
- R4: While carrier is high, the delimiter is a dibit `11` that directly follows a dibit `01`. The first dibit of a carrier burst cannot be the second half of a delimiter.
- R5: After the delimiter, every four sampled data dibits form one byte. The first dibit goes to bits [1:0] and the fourth goes to bits [7:6].
- R6: The first byte of each frame has `byte_sof` high in the same cycle as `byte_valid`.
- R7: A completed byte is held until the next byte completes or the frame ends. Only then is it emitted with a one-clock `byte_valid` pulse.
- R8: A single sample with carrier low during a frame does not end the frame. The dibit in that sample is not packed.
- R9: Two consecutive samples with carrier low end the frame. The last complete byte is then emitted with `byte_eof` high.
- R10: If a frame ends with 1 to 3 data dibits left over, those dibits are dropped and `align_err` pulses for one clock. The pulse comes in the same clock as the `byte_eof` of the last complete byte, if that byte exists.
- R11: The delimiter must fall within the first 32 dibits of a carrier burst. If it does not, the burst is ignored until a sample with carrier low.
- R12: A sample with carrier low while hunting ends the hunt. A new burst is then needed before a delimiter is accepted.
- R13: `byte_valid` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_10m | input | 1 | High selects one sample in ten (10 Mb/s) |
| crs_dv | input | 1 | Carrier sense / receive data valid from the PHY |
| rxd | input | 2 | Receive dibit from the PHY |
| byte_data | output | 8 | Received byte, meaningful while `byte_valid` is high |
| byte_valid | output | 1 | One-clock strobe for an output byte |
| byte_sof | output | 1 | Marks the first byte of a frame |
| byte_eof | output | 1 | Marks the last complete byte of a frame |
| align_err | output | 1 | Frame ended with a partial byte |

## Verification
The last-byte flag and the alignment-error pulse can fall in the same cycle. The bench provokes this by ending a frame two dibits after a byte boundary, with a complete byte still held back. A behavioural reference model is compared with every output on every clock, and a separate tally counts the cycles where `byte_eof` and `align_err` rise together. A second collision comes from a one-sample carrier dropout in the middle of a byte. There the bench checks that the byte keeps its value and that the frame continues.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef enum logic [1:0] {
    HS_IDLE,
    HS_HUNT,
    HS_DROP,
    HS_DATA
  } hunt_state_e;

  localparam logic [1:0] DIBIT_PRE = 2'b01;
  localparam logic [1:0] DIBIT_SFD = 2'b11;
endpackage

// File: rtl/rmii_sample_gate.sv
module rmii_sample_gate #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_10m,
  output logic strobe
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] phase_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_cnt <= '0;
    end else if (phase_cnt == LAST) begin
      phase_cnt <= '0;
    end else begin
      phase_cnt <= phase_cnt + 1'b1;
    end
  end

  assign strobe = !mode_10m || (phase_cnt == LAST);

  AST_SLOW_STROBE_SPACED: assert property (@(posedge clk) disable iff (rst)
    (mode_10m && strobe) |=> !(mode_10m && strobe)); // R2
endmodule

// File: rtl/rmii_sfd_hunter.sv
module rmii_sfd_hunter
  import rmii_rx_pkg::*;
#(
  parameter int PRE_LIMIT = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic       crs_dv,
  input  logic [1:0] rxd,
  output logic       pack_en,
  output logic       frame_go,
  output logic       frame_end
);
  localparam int HW = $clog2(PRE_LIMIT + 1);
  localparam logic [HW-1:0] HLIM = HW'(PRE_LIMIT);

  hunt_state_e state, state_n;
  logic [HW-1:0] hcnt, hcnt_n;
  logic          prev_pre, prev_pre_n;
  logic          low_pend, low_pend_n;

  always_comb begin
    state_n    = state;
    hcnt_n     = hcnt;
    prev_pre_n = prev_pre;
    low_pend_n = low_pend;
    pack_en    = 1'b0;
    frame_go   = 1'b0;
    frame_end  = 1'b0;
    if (strobe) begin
      case (state)
        HS_IDLE: begin
          if (crs_dv) begin
            state_n    = HS_HUNT;
            hcnt_n     = HW'(1);
            prev_pre_n = (rxd == DIBIT_PRE);
          end
        end
        HS_HUNT: begin
          if (!crs_dv) begin
            state_n = HS_IDLE;
          end else if (hcnt == HLIM) begin
            state_n = HS_DROP;
          end else if (rxd == DIBIT_SFD && prev_pre) begin
            state_n    = HS_DATA;
            frame_go   = 1'b1;
            low_pend_n = 1'b0;
          end else begin
            hcnt_n     = hcnt + 1'b1;
            prev_pre_n = (rxd == DIBIT_PRE);
          end
        end
        HS_DROP: begin
          if (!crs_dv) state_n = HS_IDLE;
        end
        HS_DATA: begin
          if (crs_dv) begin
            low_pend_n = 1'b0;
            pack_en    = 1'b1;
          end else if (low_pend) begin
            state_n    = HS_IDLE;
            frame_end  = 1'b1;
            low_pend_n = 1'b0;
          end else begin
            low_pend_n = 1'b1;
          end
        end
        default: state_n = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= HS_IDLE;
      hcnt     <= '0;
      prev_pre <= 1'b0;
      low_pend <= 1'b0;
    end else begin
      state    <= state_n;
      hcnt     <= hcnt_n;
      prev_pre <= prev_pre_n;
      low_pend <= low_pend_n;
    end
  end

  AST_HUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == HS_HUNT) |-> (hcnt <= HLIM)); // R11

  AST_GAP_THEN_END: assert property (@(posedge clk) disable iff (rst)
    (frame_end) |-> (state == HS_DATA && low_pend)); // R9
endmodule

// File: rtl/rmii_byte_packer.sv
module rmii_byte_packer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pack_en,
  input  logic              frame_go,
  input  logic              frame_end,
  input  logic [1:0]        rxd,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_err
);
  localparam int STEPS = DATA_W / 2;
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] next_word;
  logic [SW-1:0]     dcnt;
  logic              held_vld;
  logic              held_first;
  logic              first_pend;

  assign next_word = {rxd, shreg[DATA_W-1:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg      <= '0;
      held       <= '0;
      dcnt       <= '0;
      held_vld   <= 1'b0;
      held_first <= 1'b0;
      first_pend <= 1'b0;
      out_data   <= '0;
      out_valid  <= 1'b0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_err   <= 1'b0;
      if (frame_go) begin
        dcnt       <= '0;
        held_vld   <= 1'b0;
        first_pend <= 1'b1;
      end else if (pack_en) begin
        shreg <= next_word;
        if (dcnt == LAST_STEP) begin
          dcnt <= '0;
          if (held_vld) begin
            out_valid <= 1'b1;
            out_data  <= held;
            out_sof   <= held_first;
          end
          held       <= next_word;
          held_vld   <= 1'b1;
          held_first <= first_pend;
          first_pend <= 1'b0;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end else if (frame_end) begin
        if (held_vld) begin
          out_valid <= 1'b1;
          out_data  <= held;
          out_sof   <= held_first;
          out_eof   <= 1'b1;
        end
        out_err    <= (dcnt != '0);
        held_vld   <= 1'b0;
        first_pend <= 1'b0;
        dcnt       <= '0;
      end
    end
  end

  AST_SOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid); // R6

  AST_EOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_valid); // R9

  AST_VALID_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R13

  AST_ERR_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    out_err |-> $past(frame_end)); // R10
endmodule

// File: rtl/rmii_rx_aligner.sv
module rmii_rx_aligner #(
  parameter int DATA_W    = 8,
  parameter int SLOW_DIV  = 10,
  parameter int PRE_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_10m,
  input  logic              crs_dv,
  input  logic [1:0]        rxd,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_valid,
  output logic              byte_sof,
  output logic              byte_eof,
  output logic              align_err
);
  logic strobe;
  logic pack_en;
  logic frame_go;
  logic frame_end;

  rmii_sample_gate #(.SLOW_DIV(SLOW_DIV)) i_gate (
    .clk      (clk),
    .rst      (rst),
    .mode_10m (mode_10m),
    .strobe   (strobe)
  );

  rmii_sfd_hunter #(.PRE_LIMIT(PRE_LIMIT)) i_hunter (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .crs_dv    (crs_dv),
    .rxd       (rxd),
    .pack_en   (pack_en),
    .frame_go  (frame_go),
    .frame_end (frame_end)
  );

  rmii_byte_packer #(.DATA_W(DATA_W)) i_packer (
    .clk       (clk),
    .rst       (rst),
    .pack_en   (pack_en),
    .frame_go  (frame_go),
    .frame_end (frame_end),
    .rxd       (rxd),
    .out_data  (byte_data),
    .out_valid (byte_valid),
    .out_sof   (byte_sof),
    .out_eof   (byte_eof),
    .out_err   (align_err)
  );
endmodule

// File: tb/test_rmii_rx_aligner.sv
module test_rmii_rx_aligner;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_10m = 1'b0;
  logic       crs_dv = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic [7:0] byte_data;
  logic       byte_valid, byte_sof, byte_eof, align_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit started = 0;

  always #4 clk = ~clk;

  rmii_rx_aligner i_rmii_rx_aligner (
    .clk(clk), .rst(rst), .mode_10m(mode_10m), .crs_dv(crs_dv), .rxd(rxd),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_sof(byte_sof),
    .byte_eof(byte_eof), .align_err(align_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference model
  int ph = 0, mcnt = 0, seen = 0;
  bit last01 = 0, gap = 0, have = 0, heldfirst = 0, firstp = 0;
  logic [7:0] held = 0;
  logic [1:0] dq[$];
  logic [7:0] e_data = 0;
  bit e_valid = 0, e_sof = 0, e_eof = 0, e_err = 0;

  always @(posedge clk) begin
    bit stb;
    started = 1;
    if (rst) begin
      mcnt = 0; ph = 0; seen = 0; last01 = 0; gap = 0; have = 0; firstp = 0;
      dq.delete();
      e_valid = 0; e_sof = 0; e_eof = 0; e_err = 0;
    end else begin
      e_valid = 0; e_sof = 0; e_eof = 0; e_err = 0;
      stb = !mode_10m || (mcnt == 9);
      mcnt = (mcnt == 9) ? 0 : mcnt + 1;
      if (stb) begin
        if (ph == 0) begin
          if (crs_dv) begin ph = 1; seen = 1; last01 = (rxd == 2'b01); end
        end else if (ph == 1) begin
          if (!crs_dv) ph = 0;
          else if (seen == 32) ph = 2;
          else if (rxd == 2'b11 && last01) begin
            ph = 3; dq.delete(); have = 0; firstp = 1; gap = 0;
          end else begin seen++; last01 = (rxd == 2'b01); end
        end else if (ph == 2) begin
          if (!crs_dv) ph = 0;
        end else begin
          if (crs_dv) begin
            gap = 0;
            dq.push_back(rxd);
            if (dq.size() == 4) begin
              if (have) begin e_valid = 1; e_data = held; e_sof = heldfirst; end
              held = {dq[3], dq[2], dq[1], dq[0]};
              dq.delete();
              have = 1; heldfirst = firstp; firstp = 0;
            end
          end else if (gap) begin
            ph = 0; gap = 0;
            if (have) begin e_valid = 1; e_data = held; e_sof = heldfirst; e_eof = 1; end
            have = 0;
            if (dq.size() != 0) e_err = 1;
            dq.delete();
          end else gap = 1;
        end
      end
    end
  end

  // observation tallies
  int n_valid = 0, n_sof = 0, n_eof = 0, n_err = 0, n_both = 0, n_b2b = 0;
  logic [7:0] got[$];
  bit prev_valid = 0;

  always @(negedge clk) begin
    if (started) begin
      chk(byte_valid === e_valid, "R7 valid", byte_valid, e_valid);
      chk(byte_sof === e_sof, "R6 sof", byte_sof, e_sof);
      chk(byte_eof === e_eof, "R9 eof", byte_eof, e_eof);
      chk(align_err === e_err, "R10 align", align_err, e_err);
      if (e_valid) chk(byte_data === e_data, "R5 data", byte_data, e_data);
      if (byte_valid === 1'b1) begin n_valid++; got.push_back(byte_data); end
      if (byte_sof === 1'b1) n_sof++;
      if (byte_eof === 1'b1) n_eof++;
      if (align_err === 1'b1) n_err++;
      if (byte_eof === 1'b1 && align_err === 1'b1) n_both++;
      if (byte_valid === 1'b1 && prev_valid) n_b2b++;
      prev_valid = (byte_valid === 1'b1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic clr();
    n_valid = 0; n_sof = 0; n_eof = 0; n_err = 0; n_both = 0;
    got.delete();
  endtask

  task automatic dib(input logic c, input logic [1:0] d);
    crs_dv = c; rxd = d;
    repeat (mode_10m ? 10 : 1) @(negedge clk);
  endtask

  task automatic pre(input int n);
    for (int i = 0; i < n; i++) dib(1'b1, 2'b01);
  endtask

  task automatic sfd();
    dib(1'b1, 2'b11);
  endtask

  task automatic put(input logic [7:0] b);
    for (int i = 0; i < 4; i++) dib(1'b1, b[2*i +: 2]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) dib(1'b0, 2'b00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: outputs quiet in reset
    chk(byte_valid === 0 && byte_sof === 0 && byte_eof === 0 && align_err === 0,
        "R1 reset", {byte_valid, byte_sof, byte_eof, align_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(byte_valid === 0 && align_err === 0, "R1 after reset", byte_valid, 0);
    idle(3);

    // plain frame
    clr();
    pre(7); sfd(); put(8'h12); put(8'hA5); put(8'hFF); put(8'h00); idle(4);
    chk(n_valid == 4, "R5 byte count", n_valid, 4);
    chk(got.size() == 4 && got[0] == 8'h12, "R5 first byte", got.size() ? got[0] : 0, 8'h12);
    chk(got.size() == 4 && got[3] == 8'h00, "R9 last byte", got.size() ? got[3] : 0, 0);
    chk(n_sof == 1, "R6 sof count", n_sof, 1);
    chk(n_eof == 1, "R9 eof count", n_eof, 1);

    // R4: junk before delimiter, first dibit 11 is not a delimiter
    clr();
    dib(1, 2'b11); dib(1, 2'b10); dib(1, 2'b00); dib(1, 2'b01); sfd();
    put(8'h3C); put(8'h81); idle(3);
    chk(n_valid == 2 && got[0] == 8'h3C, "R4 delimiter", n_valid, 2);

    // R3: burst without delimiter
    clr();
    dib(1, 2'b01); dib(1, 2'b10); dib(1, 2'b11); dib(1, 2'b00); dib(1, 2'b00); idle(3);
    chk(n_valid == 0 && n_err == 0, "R3 no delimiter", n_valid, 0);

    // R8: single carrier dropout mid-byte
    clr();
    pre(3); sfd(); put(8'hA1);
    dib(1, 2'b10); dib(1, 2'b11); dib(0, 2'b10); dib(1, 2'b00); dib(1, 2'b10);
    put(8'h4E); idle(3);
    chk(n_valid == 3, "R8 count", n_valid, 3);
    chk(got.size() == 3 && got[1] == 8'h8E, "R8 byte kept", got.size() > 1 ? got[1] : 0, 8'h8E);

    // R10: partial byte at end, collides with eof
    clr();
    pre(3); sfd(); put(8'h11); put(8'h22); dib(1, 2'b01); dib(1, 2'b10); idle(3);
    chk(n_valid == 2, "R10 count", n_valid, 2);
    chk(n_err == 1, "R10 error", n_err, 1);
    chk(n_both == 1, "R10 same cycle", n_both, 1);

    // R11: delimiter as the 32nd dibit accepted, as the 33rd dropped
    clr();
    pre(31); sfd(); put(8'h5A); idle(3);
    chk(n_valid == 1 && got[0] == 8'h5A, "R11 in limit", n_valid, 1);
    clr();
    pre(32); sfd(); put(8'h5A); put(8'h13); idle(3);
    chk(n_valid == 0, "R11 past limit", n_valid, 0);

    // R12: carrier low during hunt restarts hunt
    clr();
    pre(5); dib(0, 2'b01); dib(1, 2'b11); put(8'h99); idle(3);
    chk(n_valid == 0, "R12 hunt abort", n_valid, 0);

    // R2: slow sampling
    mode_10m = 1'b1;
    idle(2);
    clr();
    pre(4); sfd(); put(8'hC3); put(8'h7E); idle(3);
    chk(n_valid == 2 && got[0] == 8'hC3, "R2 slow frame", n_valid, 2);
    chk(got.size() == 2 && got[1] == 8'h7E, "R2 slow data", got.size() > 1 ? got[1] : 0, 8'h7E);
    mode_10m = 1'b0;
    idle(3);

    chk(n_b2b == 0, "R13 spacing", n_b2b, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule